// File: doc/BRIEF.md
# Dual-Timing Microcontroller Register Port for a Tone Transceiver

This block is the processor-facing register port of a tone signalling transceiver. An external 4-bit microcontroller bus reaches it through a select line, a strobe line, a direction/write line and a single register-select line. The block decides on every select falling edge which of two bus timings is in use. If the strobe line is low, it uses the strobe-plus-direction timing. If the strobe line is high, it uses the timing with separate active-low read and write lines. All bus pins are brought into the core clock domain through a configurable synchroniser chain.

Behind the port sit five registers. They are a write-only transmit code, a read-only received digit, a read-only status word, and two control words that share one address. The second control word is reached through a one-shot redirect bit held in the first. Status flags record a newly received digit and a transmitter that has finished its burst and pause. Reading the status word clears these flags. The block also drives an active-low interrupt line. In call-progress mode, that line instead carries the squared call-progress waveform.

Top module: `tone_xcvr_regif`

## Requirements
- R1: After a synchronous reset, every control bit, the transmit code, the received digit and all status flags are 0, `irq_cp_n` is 1 and `bus_oe` is 0.
- R2: At each falling edge of `bus_sel_n`, the level of `bus_strobe` selects the timing. Low selects strobe timing: `bus_strobe` is active high, and `bus_rw`=1 means read, 0 means write. High selects split timing: `bus_strobe` low is a read and `bus_rw` low is a write.
- R3: `bus_rs`=0 with a write loads the transmit code, and with a read returns the received digit. `bus_rs`=1 with a write goes to a control word, and with a read returns the status word.
- R4: Only the first strobe of a select assertion performs an access. Later strobes before `bus_sel_n` rises neither write nor drive the bus.
- R5: Write data is taken when the active write strobe ends. `bus_oe` is high only during the accepted read strobe while the select is low.
- R6: The first control word's bit 0 is `tone_enable`, bit 1 `cp_mode`, bit 2 `irq_enable` and bit 3 the redirect bit. The second control word's bit 0 is `burst_off`, bit 1 `rx_powerdown`, bit 2 `single_tone` and bit 3 `column_sel`.
- R7: A first-word write with bit 3 set sends only the next control-address write to the second word. Control writes after that go to the first word again.
- R8: The status word has bit 0 = interrupt pending, bit 1 = transmitter ready, bit 2 = digit received, and bit 3 = the live `steer_delayed` input. Bit 0 is set together with bit 1 or bit 2.
- R9: A status read returns the flags as they were. Bits 0 to 2 are zero after that read.
- R10: A `tx_ready` pulse sets the ready flag only while `burst_off`=0. Status bit 1 reads 0 whenever `burst_off`=1.
- R11: A first-word write with bit 0 = 0 clears the transmit code. A write with bit 0 = 1 leaves it unchanged.
- R12: With `irq_enable`=0, `irq_cp_n` is 1. With `irq_enable`=1 and `cp_mode`=0, `irq_cp_n` is low exactly while the interrupt flag is set. With both set, `irq_cp_n` follows `cp_wave`.
- R13: A `rx_valid` pulse loads `rx_digit` into the received-digit register on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_sel_n | input | 1 | Bus select, active low, asynchronous |
| bus_strobe | input | 1 | Data strobe (strobe timing) or read, active low (split timing) |
| bus_rw | input | 1 | Read/write direction (strobe timing) or write, active low (split timing) |
| bus_rs | input | 1 | Register select |
| bus_din | input | BUS_W | Write data from the bus |
| bus_dout | output | BUS_W | Read data to the bus |
| bus_oe | output | 1 | Read data drive enable |
| rx_valid | input | 1 | One-cycle pulse: a digit has been validated |
| rx_digit | input | BUS_W | Code of the validated digit |
| steer_delayed | input | 1 | Delayed steering level shown in status bit 3 |
| tx_ready | input | 1 | One-cycle pulse: burst and pause completed |
| cp_wave | input | 1 | Squared call-progress waveform |
| irq_cp_n | output | 1 | Active-low interrupt, or call-progress wave |
| tx_code | output | BUS_W | Transmit code register |
| tone_enable | output | 1 | Control: transmitter enabled |
| cp_mode | output | 1 | Control: call-progress mode |
| irq_enable | output | 1 | Control: interrupt line enabled |
| burst_off | output | 1 | Control: burst timing disabled |
| rx_powerdown | output | 1 | Control: receiver powered down |
| single_tone | output | 1 | Control: single-tone generation |
| column_sel | output | 1 | Control: column rather than row tone |

## Verification
Properties checked on every clock cover these rules:
- The drive enable never rises without a synchronised select.
- An access is never committed in two consecutive cycles.
- The interrupt line stays idle when interrupts are disabled, and follows the waveform in call-progress mode.
- The ready flag stays masked without burst timing.
- A received pulse loads the digit.
- A status read leaves the flags clear when no event arrives in the same cycle.

Several behaviours can only be shown by the bench's scenarios:
- Per-access timing detection from the strobe level.
- Register decoding for all sixteen codes under both timings.
- The one-shot redirect to the second control word.
- Ignoring second strobes within a single select.
- Clearing of the transmit code by disabling the tone.

// File: rtl/regif_pkg.sv
package regif_pkg;
   typedef enum logic {
      TIMING_STROBE = 1'b0,
      TIMING_SPLIT  = 1'b1
   } timing_e;

   localparam int CTL_W = 4;

   // first control word
   localparam int A_TONE  = 0;
   localparam int A_CP    = 1;
   localparam int A_IRQ   = 2;
   localparam int A_REDIR = 3;

   // second control word
   localparam int B_BURST_OFF = 0;
   localparam int B_RX_PD     = 1;
   localparam int B_SINGLE    = 2;
   localparam int B_COLUMN    = 3;

   // status word
   localparam int S_IRQ   = 0;
   localparam int S_TXRDY = 1;
   localparam int S_RXFUL = 2;
   localparam int S_STEER = 3;
endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
   parameter int W = 1,
   parameter int STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d_async,
   output logic [W-1:0] q
);
   logic [W-1:0] pipe [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (rst) pipe[g] <= RST_VAL;
            else     pipe[g] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk) begin
            if (rst) pipe[g] <= RST_VAL;
            else     pipe[g] <= pipe[g-1];
         end
      end
   end

   assign q = pipe[STAGES-1];
endmodule

// File: rtl/regif_access.sv
module regif_access
   import regif_pkg::*;
(
   input  logic clk,
   input  logic rst,
   input  logic sel_n,
   input  logic strobe,
   input  logic rw,
   input  logic rs,
   output logic wr_commit,
   output logic rd_commit,
   output logic commit_sel,
   output logic rd_live
);
   timing_e timing;
   logic    sel_n_q, armed, act_q, rd_q, rs_q;
   logic    sel_fall, rd_strb, wr_strb, acc_act, acc_rd, acc_end;

   assign sel_fall = sel_n_q & ~sel_n;

   always_comb begin
      if (timing == TIMING_STROBE) begin
         rd_strb = strobe & rw;
         wr_strb = strobe & ~rw;
      end else begin
         rd_strb = ~strobe;
         wr_strb = ~rw;
      end
   end

   assign acc_act = armed & ~sel_n & (rd_strb | wr_strb);
   assign acc_rd  = armed & ~sel_n & rd_strb;
   assign acc_end = act_q & ~acc_act;

   always_ff @(posedge clk) begin
      if (rst) begin
         sel_n_q <= 1'b1;
         timing  <= TIMING_STROBE;
         armed   <= 1'b0;
         act_q   <= 1'b0;
         rd_q    <= 1'b0;
         rs_q    <= 1'b0;
      end else begin
         sel_n_q <= sel_n;
         if (sel_fall) begin
            timing <= strobe ? TIMING_SPLIT : TIMING_STROBE;
            armed  <= 1'b1;
         end else if (acc_end) begin
            armed  <= 1'b0;
         end
         act_q <= acc_act;
         rd_q  <= acc_rd;
         if (acc_act) rs_q <= rs;
      end
   end

   assign wr_commit  = acc_end & ~rd_q;
   assign rd_commit  = acc_end & rd_q;
   assign commit_sel = rs_q;
   assign rd_live    = acc_rd;
endmodule

// File: rtl/regif_regs.sv
module regif_regs
   import regif_pkg::*;
#(
   parameter int BUS_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_commit,
   input  logic             rd_commit,
   input  logic             commit_sel,
   input  logic             read_sel,
   input  logic [BUS_W-1:0] din,
   input  logic             rx_valid,
   input  logic [BUS_W-1:0] rx_digit,
   input  logic             tx_ready,
   input  logic             steer_delayed,
   input  logic             cp_wave,
   output logic [BUS_W-1:0] dout,
   output logic [BUS_W-1:0] tx_code,
   output logic [BUS_W-1:0] rx_data,
   output logic [BUS_W-1:0] status,
   output logic [CTL_W-1:0] ctl_a,
   output logic [CTL_W-1:0] ctl_b,
   output logic             irq_cp_n
);
   logic rx_full, tx_empty, irq_flag, clr, tx_set;

   assign clr    = rd_commit & commit_sel;
   assign tx_set = tx_ready & ~ctl_b[B_BURST_OFF];

   always_ff @(posedge clk) begin
      if (rst) begin
         tx_code  <= '0;
         rx_data  <= '0;
         ctl_a    <= '0;
         ctl_b    <= '0;
         rx_full  <= 1'b0;
         tx_empty <= 1'b0;
         irq_flag <= 1'b0;
      end else begin
         if (wr_commit && !commit_sel) tx_code <= din;
         if (wr_commit && commit_sel) begin
            if (ctl_a[A_REDIR]) begin
               ctl_b           <= din[CTL_W-1:0];
               ctl_a[A_REDIR]  <= 1'b0;
            end else begin
               ctl_a <= din[CTL_W-1:0];
               if (!din[A_TONE]) tx_code <= '0;
            end
         end
         if (rx_valid) rx_data <= rx_digit;
         rx_full  <= rx_valid | (rx_full & ~clr);
         tx_empty <= tx_set | (tx_empty & ~clr);
         irq_flag <= rx_valid | tx_set | (irq_flag & ~clr);
      end
   end

   always_comb begin
      status          = '0;
      status[S_IRQ]   = irq_flag;
      status[S_TXRDY] = tx_empty & ~ctl_b[B_BURST_OFF];
      status[S_RXFUL] = rx_full;
      status[S_STEER] = steer_delayed;
   end

   assign dout = read_sel ? status : rx_data;

   always_comb begin
      if (!ctl_a[A_IRQ])    irq_cp_n = 1'b1;
      else if (ctl_a[A_CP]) irq_cp_n = cp_wave;
      else                  irq_cp_n = ~irq_flag;
   end
endmodule

// File: rtl/tone_xcvr_regif.sv
module tone_xcvr_regif
   import regif_pkg::*;
#(
   parameter int BUS_W = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bus_sel_n,
   input  logic             bus_strobe,
   input  logic             bus_rw,
   input  logic             bus_rs,
   input  logic [BUS_W-1:0] bus_din,
   output logic [BUS_W-1:0] bus_dout,
   output logic             bus_oe,
   input  logic             rx_valid,
   input  logic [BUS_W-1:0] rx_digit,
   input  logic             steer_delayed,
   input  logic             tx_ready,
   input  logic             cp_wave,
   output logic             irq_cp_n,
   output logic [BUS_W-1:0] tx_code,
   output logic             tone_enable,
   output logic             cp_mode,
   output logic             irq_enable,
   output logic             burst_off,
   output logic             rx_powerdown,
   output logic             single_tone,
   output logic             column_sel
);
   localparam int PINS = 4;
   localparam logic [PINS-1:0] PIN_IDLE = 4'b1000;

   if (BUS_W < CTL_W) begin : g_bad_width
      $error("BUS_W must be at least the control word width");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [PINS-1:0]  pins_s;
   logic             cs_s, strb_s, rw_s, rs_s;
   logic             wr_commit, rd_commit, commit_sel, rd_live;
   logic [BUS_W-1:0] status_w, rx_data_w;
   logic [CTL_W-1:0] ctl_a_w, ctl_b_w;

   regif_sync #(.W(PINS), .STAGES(SYNC_STAGES), .RST_VAL(PIN_IDLE)) u_sync (
      .clk     (clk),
      .rst     (rst),
      .d_async ({bus_sel_n, bus_strobe, bus_rw, bus_rs}),
      .q       (pins_s)
   );
   assign {cs_s, strb_s, rw_s, rs_s} = pins_s;

   regif_access u_acc (
      .clk        (clk),
      .rst        (rst),
      .sel_n      (cs_s),
      .strobe     (strb_s),
      .rw         (rw_s),
      .rs         (rs_s),
      .wr_commit  (wr_commit),
      .rd_commit  (rd_commit),
      .commit_sel (commit_sel),
      .rd_live    (rd_live)
   );

   regif_regs #(.BUS_W(BUS_W)) u_regs (
      .clk           (clk),
      .rst           (rst),
      .wr_commit     (wr_commit),
      .rd_commit     (rd_commit),
      .commit_sel    (commit_sel),
      .read_sel      (rs_s),
      .din           (bus_din),
      .rx_valid      (rx_valid),
      .rx_digit      (rx_digit),
      .tx_ready      (tx_ready),
      .steer_delayed (steer_delayed),
      .cp_wave       (cp_wave),
      .dout          (bus_dout),
      .tx_code       (tx_code),
      .rx_data       (rx_data_w),
      .status        (status_w),
      .ctl_a         (ctl_a_w),
      .ctl_b         (ctl_b_w),
      .irq_cp_n      (irq_cp_n)
   );

   assign bus_oe       = rd_live;
   assign tone_enable  = ctl_a_w[A_TONE];
   assign cp_mode      = ctl_a_w[A_CP];
   assign irq_enable   = ctl_a_w[A_IRQ];
   assign burst_off    = ctl_b_w[B_BURST_OFF];
   assign rx_powerdown = ctl_b_w[B_RX_PD];
   assign single_tone  = ctl_b_w[B_SINGLE];
   assign column_sel   = ctl_b_w[B_COLUMN];
endmodule

// File: rtl/tone_xcvr_regif_chk.sv
module tone_xcvr_regif_chk #(
   parameter int BUS_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             cs_s,
   input logic             bus_oe,
   input logic             wr_commit,
   input logic             rd_commit,
   input logic             commit_sel,
   input logic             irq_en,
   input logic             cp_on,
   input logic             burst_off,
   input logic             irq_cp_n,
   input logic             cp_wave,
   input logic             rx_valid,
   input logic             tx_ready,
   input logic [BUS_W-1:0] rx_digit,
   input logic [BUS_W-1:0] rx_data,
   input logic [BUS_W-1:0] status
);
   assert_oe_in_select_R5: assert property (@(posedge clk) disable iff (rst)
      bus_oe |-> !cs_s);

   assert_single_commit_R4: assert property (@(posedge clk) disable iff (rst)
      (wr_commit || rd_commit) |=> !(wr_commit || rd_commit));

   assert_irq_idle_R12: assert property (@(posedge clk) disable iff (rst)
      !irq_en |-> irq_cp_n);

   assert_cp_follow_R12: assert property (@(posedge clk) disable iff (rst)
      (irq_en && cp_on) |-> (irq_cp_n == cp_wave));

   assert_rx_irq_R12: assert property (@(posedge clk) disable iff (rst)
      (rx_valid && irq_en && !cp_on) |=> (!irq_cp_n || cp_on || !irq_en));

   assert_txrdy_masked_R10: assert property (@(posedge clk) disable iff (rst)
      burst_off |-> !status[1]);

   assert_rx_load_R13: assert property (@(posedge clk) disable iff (rst)
      rx_valid |=> (rx_data == $past(rx_digit)));

   assert_status_clear_R9: assert property (@(posedge clk) disable iff (rst)
      (rd_commit && commit_sel && !rx_valid && !tx_ready) |=> (status[2:0] == 3'b000));
endmodule

bind tone_xcvr_regif tone_xcvr_regif_chk #(.BUS_W(BUS_W)) u_chk (
   .clk        (clk),
   .rst        (rst),
   .cs_s       (cs_s),
   .bus_oe     (bus_oe),
   .wr_commit  (wr_commit),
   .rd_commit  (rd_commit),
   .commit_sel (commit_sel),
   .irq_en     (irq_enable),
   .irq_cp_n   (irq_cp_n),
   .cp_on      (cp_mode),
   .burst_off  (burst_off),
   .cp_wave    (cp_wave),
   .rx_valid   (rx_valid),
   .tx_ready   (tx_ready),
   .rx_digit   (rx_digit),
   .rx_data    (rx_data_w),
   .status     (status_w)
);

// File: tb/tone_xcvr_regif_test.sv
module tone_xcvr_regif_test;
   localparam int CLK_PERIOD = 10;
   localparam int GAP = 4;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       bus_sel_n = 1'b1, bus_strobe = 1'b0, bus_rw = 1'b1, bus_rs = 1'b0;
   logic [3:0] bus_din = '0, rx_digit = '0;
   logic       rx_valid = 1'b0, steer_delayed = 1'b0, tx_ready = 1'b0, cp_wave = 1'b0;
   logic [3:0] bus_dout, tx_code;
   logic       bus_oe, irq_cp_n, tone_enable, cp_mode, irq_enable;
   logic       burst_off, rx_powerdown, single_tone, column_sel;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   tone_xcvr_regif uut (
      .clk(clk), .rst(rst), .bus_sel_n(bus_sel_n), .bus_strobe(bus_strobe),
      .bus_rw(bus_rw), .bus_rs(bus_rs), .bus_din(bus_din), .bus_dout(bus_dout),
      .bus_oe(bus_oe), .rx_valid(rx_valid), .rx_digit(rx_digit),
      .steer_delayed(steer_delayed), .tx_ready(tx_ready), .cp_wave(cp_wave),
      .irq_cp_n(irq_cp_n), .tx_code(tx_code), .tone_enable(tone_enable),
      .cp_mode(cp_mode), .irq_enable(irq_enable), .burst_off(burst_off),
      .rx_powerdown(rx_powerdown), .single_tone(single_tone), .column_sel(column_sel)
   );

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // split timing write: strobe line idles high, write line pulses low
   task automatic wr_split(input logic rs, input logic [3:0] d);
      bus_strobe = 1'b1; bus_rw = 1'b1; bus_rs = rs; bus_din = d;
      tick(GAP); bus_sel_n = 1'b0;
      tick(GAP); bus_rw = 1'b0;
      tick(GAP); bus_rw = 1'b1;
      tick(GAP); bus_sel_n = 1'b1;
      tick(GAP);
   endtask

   // strobe timing write: strobe idles low, direction low, strobe pulses high
   task automatic wr_strobe(input logic rs, input logic [3:0] d);
      bus_strobe = 1'b0; bus_rw = 1'b0; bus_rs = rs; bus_din = d;
      tick(GAP); bus_sel_n = 1'b0;
      tick(GAP); bus_strobe = 1'b1;
      tick(GAP); bus_strobe = 1'b0;
      tick(GAP); bus_sel_n = 1'b1;
      tick(GAP);
   endtask

   task automatic rd_split(input logic rs, output logic [3:0] d, output logic oe);
      bus_strobe = 1'b1; bus_rw = 1'b1; bus_rs = rs;
      tick(GAP); bus_sel_n = 1'b0;
      tick(GAP); bus_strobe = 1'b0;
      tick(GAP); d = bus_dout; oe = bus_oe;
      bus_strobe = 1'b1;
      tick(GAP); bus_sel_n = 1'b1;
      tick(GAP);
   endtask

   task automatic rd_strobe(input logic rs, output logic [3:0] d, output logic oe);
      bus_strobe = 1'b0; bus_rw = 1'b1; bus_rs = rs;
      tick(GAP); bus_sel_n = 1'b0;
      tick(GAP); bus_strobe = 1'b1;
      tick(GAP); d = bus_dout; oe = bus_oe;
      bus_strobe = 1'b0;
      tick(GAP); bus_sel_n = 1'b1;
      tick(GAP);
   endtask

   task automatic rd_any(input bit split, input logic rs, output logic [3:0] d);
      logic oe;
      if (split) rd_split(rs, d, oe);
      else       rd_strobe(rs, d, oe);
      check("R5 read drive enable", oe, 1);
   endtask

   task automatic pulse_rx(input logic [3:0] dig);
      rx_digit = dig; rx_valid = 1'b1;
      tick(1); rx_valid = 1'b0;
      tick(1);
   endtask

   task automatic pulse_tx;
      tx_ready = 1'b1;
      tick(1); tx_ready = 1'b0;
      tick(1);
   endtask

   initial begin
      tick(150000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      logic [3:0] d;
      logic       oe;
      tick(4);
      rst = 1'b0;
      tick(2);

      // R1 reset state
      check("R1 tx_code", tx_code, 0);
      check("R1 controls", {tone_enable, cp_mode, irq_enable, burst_off,
                            rx_powerdown, single_tone, column_sel}, 0);
      check("R1 irq_cp_n", irq_cp_n, 1);
      check("R1 bus_oe", bus_oe, 0);
      rd_strobe(1'b1, d, oe);
      check("R1 status", d, 0);

      // R2 R3 R5: transmit code sweep under both timings
      for (int i = 0; i < 16; i++) begin
         wr_split(1'b0, 4'(i));
         check("R2 R3 split write tx_code", tx_code, i);
         wr_strobe(1'b0, 4'(15 - i));
         check("R2 R3 strobe write tx_code", tx_code, 15 - i);
      end

      // R4: second write strobe in one select is ignored
      bus_strobe = 1'b1; bus_rw = 1'b1; bus_rs = 1'b0; bus_din = 4'h5;
      tick(GAP); bus_sel_n = 1'b0;
      tick(GAP); bus_rw = 1'b0;
      tick(GAP); bus_rw = 1'b1;
      tick(GAP); bus_din = 4'h9;
      tick(GAP); bus_rw = 1'b0;
      tick(GAP); bus_rw = 1'b1;
      tick(GAP); bus_sel_n = 1'b1;
      tick(GAP);
      check("R4 second write ignored", tx_code, 5);

      // R4: second read strobe does not drive the bus
      bus_strobe = 1'b0; bus_rw = 1'b1; bus_rs = 1'b1;
      tick(GAP); bus_sel_n = 1'b0;
      tick(GAP); bus_strobe = 1'b1;
      tick(GAP); check("R4 first read drives", bus_oe, 1);
      bus_strobe = 1'b0;
      tick(GAP); bus_strobe = 1'b1;
      tick(GAP); check("R4 second read silent", bus_oe, 0);
      bus_strobe = 1'b0;
      tick(GAP); bus_sel_n = 1'b1;
      tick(GAP);
      check("R5 oe idle after select", bus_oe, 0);

      // R6 R7: control words and one-shot redirect
      wr_split(1'b1, 4'b0111);
      check("R6 first word", {irq_enable, cp_mode, tone_enable}, 3'b111);
      wr_strobe(1'b1, 4'b1001);
      wr_split(1'b1, 4'b1111);
      check("R6 R7 second word", {column_sel, single_tone, rx_powerdown, burst_off}, 4'b1111);
      check("R7 first word kept", {irq_enable, cp_mode, tone_enable}, 3'b001);
      wr_strobe(1'b1, 4'b0010);
      check("R7 back to first word", {irq_enable, cp_mode, tone_enable}, 3'b010);
      check("R7 second word kept", {column_sel, single_tone, rx_powerdown, burst_off}, 4'b1111);

      // R11: disabling the tone clears the transmit code
      wr_split(1'b1, 4'b0001);
      wr_split(1'b0, 4'h3);
      wr_strobe(1'b1, 4'b0001);
      check("R11 tone on keeps code", tx_code, 3);
      wr_strobe(1'b1, 4'b0000);
      check("R11 tone off clears code", tx_code, 0);

      // R10: ready pulse ignored while burst_off=1
      pulse_tx();
      rd_any(1'b1, 1'b1, d);
      check("R10 ready masked", d, 4'b0000);
      wr_split(1'b1, 4'b1000);
      wr_split(1'b1, 4'b0000);
      check("R10 burst enabled", burst_off, 0);
      pulse_tx();
      rd_any(1'b0, 1'b1, d);
      check("R8 R10 ready flags", d, 4'b0011);
      rd_any(1'b1, 1'b1, d);
      check("R9 flags cleared", d, 4'b0000);

      // R8: steering level in bit 3
      steer_delayed = 1'b1;
      rd_any(1'b0, 1'b1, d);
      check("R8 steer bit", d, 4'b1000);
      steer_delayed = 1'b0;

      // R12: interrupt line
      wr_split(1'b1, 4'b0100);
      check("R12 idle enabled", irq_cp_n, 1);
      pulse_rx(4'h6);
      check("R12 low on digit", irq_cp_n, 0);
      rd_any(1'b1, 1'b1, d);
      check("R8 rx flags", d, 4'b0101);
      check("R12 released after read", irq_cp_n, 1);
      pulse_tx();
      check("R12 low on ready", irq_cp_n, 0);
      rd_any(1'b0, 1'b1, d);
      check("R12 released again", irq_cp_n, 1);
      wr_strobe(1'b1, 4'b0110);
      cp_wave = 1'b1; tick(1);
      check("R12 cp wave high", irq_cp_n, 1);
      cp_wave = 1'b0; tick(1);
      check("R12 cp wave low", irq_cp_n, 0);
      wr_strobe(1'b1, 4'b0010);
      check("R12 disabled idle", irq_cp_n, 1);

      // R13 R9 R3: received digit sweep
      for (int i = 0; i < 16; i++) begin
         pulse_rx(4'(i));
         rd_any(i[0], 1'b0, d);
         check("R13 R3 digit read", d, i);
         rd_any(~i[0], 1'b1, d);
         check("R9 status before clear", d, 4'b0101);
         rd_any(i[0], 1'b1, d);
         check("R9 status after clear", d, 4'b0000);
      end

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule